// File: doc/BRIEF.md
# Prescaled Reloading Tick Timer

This block produces a periodic tick interrupt for a real-time-clock peripheral. A 32768 Hz clock-enable strobe, arriving as a one-cycle pulse on the system clock, is divided by a power of two chosen by software. Each divided strobe decrements a down-counter. When the counter runs out it raises a sticky pending flag, and that flag drives the interrupt line. The counter then reloads from the stored count and keeps running, so the tick period is the stored count times 2^N base strobes.

Software uses four word registers. The control word holds a master enable, a tick enable and a 4-bit divider select. The count register holds the reload value. A read-only register shows the live counter. The pending register has one flag that software clears by writing 1 to it. The counter starts only when the tick enable changes from 0 to 1 while the master enable is set, and only if the stored count is nonzero. Clearing either enable stops the counter.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `tick_irq` is low.
- R2: A write to the count register (address 1) is accepted only if its low CNT_W bits are greater than 2. Values 0, 1 and 2 leave the stored count unchanged.
- R3: With divider select N in control bits 7:4, the counter advances once every 2^N base strobes. The first advance falls on the 2^N-th strobe after the master enable was last set.
- R4: A control write (address 0) with bit 0 (master) set and bit 8 (tick enable) set, where the stored tick enable was 0, loads the live counter with the stored count and starts it. If the stored count is zero, nothing starts and the live counter is unchanged.
- R5: While running, each divided strobe decrements the live counter by one. On the strobe that finds it at 1, the counter reloads the stored count, pending bit 0 is set and `tick_irq` goes high.
- R6: A control write that clears the tick enable while the master enable is set stops the counter. The live value then holds through further strobes.
- R7: A control write that clears the master enable stops the counter and resets the divider. Setting the master enable again while the stored tick enable is already 1 does not restart the counter.
- R8: Writing 1 to bit 0 of the pending register (address 3) clears the flag and drops `tick_irq`. Writing 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R9: The divider select is updated only by control writes that have bit 0 set. Otherwise the old select is kept.
- R10: Address 0 reads back master in bit 0, select in bits 7:4 and tick enable in bit 8. Address 1 reads the count. Address 2 reads the live counter and ignores writes. Address 3 reads the pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_stb | input | 1 | One-cycle pulse at the 32768 Hz base rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tick_irq | output | 1 | Tick interrupt, high while the pending flag is set |

## Verification
The hardest situation to reach is a software clear of the pending flag in the same cycle as a counter expiry. The bench counts divided strobes down until the live counter reads 1. It then drives the last strobe and the clear write on one clock edge and expects the flag to stay set. A second awkward case is turning the master enable back on while the tick enable bit stays 1. The bench reaches it by switching only bit 0 and then checks that many further strobes leave the live counter frozen.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  localparam int SEL_W = 4;
  localparam int DIV_W = (1 << SEL_W) - 1;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_LIVE  = 2'd2,
    ADDR_PEND  = 2'd3
  } tick_addr_e;

  typedef struct packed {
    logic             tick_en;
    logic [SEL_W-1:0] sel;
    logic             master;
  } tick_ctrl_t;

  // Bit positions inside the control word
  localparam int MASTER_BIT = 0;
  localparam int SEL_LSB    = 4;
  localparam int TICK_BIT   = 8;

  // Low-bit mask: the divided strobe fires when these divider bits are all ones
  function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [DIV_W:0] one_hot;
    one_hot  = '0;
    one_hot[sel] = 1'b1;
    return DIV_W'(one_hot - 1'b1);
  endfunction

  function automatic logic [31:0] ctrl_word(input tick_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[MASTER_BIT] = c.master;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[TICK_BIT] = c.tick_en;
    return w;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import rtc_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_stb,
  input  logic             run_en,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_stb
);

  logic [DIV_W-1:0] pdiv;
  logic [DIV_W-1:0] mask;

  assign mask    = div_mask(sel);
  assign pre_stb = run_en && base_stb && ((pdiv & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)         pdiv <= '0;
    else if (!run_en)   pdiv <= '0;
    else if (base_stb)  pdiv <= pdiv + 1'b1;
  end

  // With select zero every base strobe must pass through
  a_r3_sel0_every: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && base_stb && sel == '0) |-> pre_stb);

  // The divider must be at zero right after the master enable is set
  a_r7_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> pdiv == '0);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_stb,
  input  logic             load,
  input  logic             stop,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] live,
  output logic             running,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic advance;
  assign advance = running && pre_stb && !stop && !load;
  assign expire  = advance && (live == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live    <= '0;
      running <= 1'b0;
    end else if (load) begin
      live    <= reload;
      running <= 1'b1;
    end else if (stop) begin
      running <= 1'b0;
    end else if (advance) begin
      live <= expire ? reload : live - ONE;
    end
  end

  a_r4_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running && live == $past(reload)));

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pre_stb && !stop && live > ONE) |=> live == $past(live) - ONE);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> live == $past(reload));

  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(live));

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              expire,
  output tick_ctrl_t        ctrl,
  output logic [CNT_W-1:0]  count,
  output logic              pend,
  output logic              load,
  output logic              stop
);

  function automatic logic count_accept(input logic [DATA_W-1:0] v);
    return v[CNT_W-1:0] > CNT_W'(2);
  endfunction

  logic             wr_ctrl, wr_count, wr_pend;
  logic             new_master, new_tick;
  logic [SEL_W-1:0] new_sel;

  assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_count   = reg_wr && (reg_addr == ADDR_COUNT);
  assign wr_pend    = reg_wr && (reg_addr == ADDR_PEND);
  assign new_master = reg_wdata[MASTER_BIT];
  assign new_tick   = reg_wdata[TICK_BIT];
  assign new_sel    = reg_wdata[SEL_LSB +: SEL_W];

  assign load = wr_ctrl && new_master && new_tick && !ctrl.tick_en && (count != '0);
  assign stop = wr_ctrl && ((ctrl.master && !new_master) ||
                            (new_master && ctrl.tick_en && !new_tick));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      count <= '0;
      pend  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.master  <= new_master;
        ctrl.tick_en <= new_tick;
        if (new_master) ctrl.sel <= new_sel;
      end
      if (wr_count && count_accept(reg_wdata)) count <= reg_wdata[CNT_W-1:0];
      if (expire)                           pend <= 1'b1;
      else if (wr_pend && reg_wdata[0])     pend <= 1'b0;
    end
  end

  a_r2_reject_small: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count && reg_wdata[CNT_W-1:0] <= CNT_W'(2)) |=> $stable(count));

  a_r8_set_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);

  a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !reg_wdata[0] && !expire) |=> $stable(pend));

  a_r9_sel_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[MASTER_BIT]) |=> $stable(ctrl.sel));

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_stb,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_irq
);

  tick_ctrl_t       ctrl;
  logic [CNT_W-1:0] count, live;
  logic             pend, load, stop, expire, running, pre_stb;

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .expire(expire), .ctrl(ctrl), .count(count),
    .pend(pend), .load(load), .stop(stop)
  );

  tick_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .base_stb(base_stb), .run_en(ctrl.master),
    .sel(ctrl.sel), .pre_stb(pre_stb)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pre_stb(pre_stb), .load(load), .stop(stop),
    .reload(count), .live(live), .running(running), .expire(expire)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:  reg_rdata = DATA_W'(ctrl_word(ctrl));
      ADDR_COUNT: reg_rdata = DATA_W'(count);
      ADDR_LIVE:  reg_rdata = DATA_W'(live);
      default:    reg_rdata = DATA_W'(pend);
    endcase
  end

  assign tick_irq = pend;

  // The counter never runs while the stored master enable is clear
  a_r7_master_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.master |-> !running);

endmodule

// File: tb/tb_rtc_tick_timer.sv
module tb_rtc_tick_timer;
  import rtc_tick_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_stb = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .base_stb(base_stb), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_irq(tick_irq)
  );

  // Control word built independently: master b0, select b7:4, tick b8
  function automatic logic [31:0] cw(input bit m, input bit t, input int n);
    return (32'(m)) | (32'(n & 15) << 4) | (32'(t) << 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stb(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_stb = 1'b1;
      @(negedge clk); base_stb = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg after reset", v, 32'd0);
    end
    chk("R1 irq after reset", 32'(tick_irq), 32'd0);
  endtask

  task automatic t_start_zero;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(1, 1, 0));
    stb(4);
    rd(ADDR_LIVE, v);
    chk("R4 zero count does not start", v, 32'd0);
    chk("R4 no irq with zero count", 32'(tick_irq), 32'd0);
    wr(ADDR_CTRL, cw(0, 0, 0));
    rd(ADDR_CTRL, v);
    chk("R10 control readback", v, 32'd0);
  endtask

  task automatic t_count_filter;
    logic [31:0] v;
    wr(ADDR_COUNT, 32'd2); rd(ADDR_COUNT, v); chk("R2 reject 2", v, 32'd0);
    wr(ADDR_COUNT, 32'd1); rd(ADDR_COUNT, v); chk("R2 reject 1", v, 32'd0);
    wr(ADDR_COUNT, 32'd5); rd(ADDR_COUNT, v); chk("R2 accept 5", v, 32'd5);
    wr(ADDR_COUNT, 32'd2); rd(ADDR_COUNT, v); chk("R2 keep after 2", v, 32'd5);
    wr(ADDR_COUNT, 32'd0); rd(ADDR_COUNT, v); chk("R2 keep after 0", v, 32'd5);
    wr(ADDR_COUNT, 32'd3); rd(ADDR_COUNT, v); chk("R2 accept 3", v, 32'd3);
    wr(ADDR_LIVE, 32'd7);  rd(ADDR_LIVE, v);  chk("R10 live ignores write", v, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(ADDR_COUNT, 32'd5);
    wr(ADDR_CTRL, cw(1, 0, 0));
    wr(ADDR_CTRL, cw(1, 1, 0));
    rd(ADDR_LIVE, v); chk("R4 load on tick rise", v, 32'd5);
    stb(1); rd(ADDR_LIVE, v); chk("R5 first decrement", v, 32'd4);
    stb(3); rd(ADDR_LIVE, v); chk("R5 at one", v, 32'd1);
    chk("R5 no irq before expiry", 32'(tick_irq), 32'd0);
    stb(1); rd(ADDR_LIVE, v); chk("R5 reload", v, 32'd5);
    chk("R5 irq on expiry", 32'(tick_irq), 32'd1);
    wr(ADDR_PEND, 32'd0); chk("R8 write 0 keeps flag", 32'(tick_irq), 32'd1);
    wr(ADDR_PEND, 32'd1); chk("R8 write 1 clears", 32'(tick_irq), 32'd0);
    rd(ADDR_PEND, v); chk("R10 pend readback", v, 32'd0);
    stb(5); chk("R5 second period irq", 32'(tick_irq), 32'd1);
    rd(ADDR_PEND, v); chk("R10 pend bit0", v, 32'd1);
    wr(ADDR_PEND, 32'd1);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(0, 0, 0));
    stb(3); rd(ADDR_LIVE, v); chk("R7 master off holds live", v, 32'd5);
    wr(ADDR_CTRL, cw(1, 0, 2));
    wr(ADDR_CTRL, cw(1, 1, 2));
    stb(3); rd(ADDR_LIVE, v); chk("R3 no advance before 4th", v, 32'd5);
    stb(1); rd(ADDR_LIVE, v); chk("R3 advance on 4th", v, 32'd4);
    stb(4); rd(ADDR_LIVE, v); chk("R3 advance on 8th", v, 32'd3);
  endtask

  task automatic t_sel_gated;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(0, 0, 15));
    rd(ADDR_CTRL, v); chk("R9 select kept without master", v, cw(0, 0, 2));
    wr(ADDR_CTRL, cw(1, 0, 2));
    wr(ADDR_CTRL, cw(1, 1, 2));
    stb(3); rd(ADDR_LIVE, v); chk("R9 old select divides", v, 32'd5);
    stb(1); rd(ADDR_LIVE, v); chk("R9 old select 4th", v, 32'd4);
  endtask

  task automatic t_tick_stop;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(1, 0, 2));
    stb(8); rd(ADDR_LIVE, v); chk("R6 tick off holds", v, 32'd4);
    rd(ADDR_CTRL, v); chk("R10 control fields", v, 32'h21);
  endtask

  task automatic t_reenable;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(1, 1, 2));
    rd(ADDR_LIVE, v); chk("R4 restart loads", v, 32'd5);
    wr(ADDR_CTRL, cw(0, 1, 2));
    rd(ADDR_CTRL, v); chk("R7 control after master off", v, 32'h120);
    wr(ADDR_CTRL, cw(1, 1, 2));
    stb(8); rd(ADDR_LIVE, v); chk("R7 no restart without tick rise", v, 32'd5);
    chk("R7 no irq", 32'(tick_irq), 32'd0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(ADDR_CTRL, cw(1, 0, 0));
    wr(ADDR_COUNT, 32'd3);
    wr(ADDR_CTRL, cw(1, 1, 0));
    stb(2); rd(ADDR_LIVE, v); chk("R5 live at one", v, 32'd1);
    @(negedge clk);
    base_stb = 1'b1; reg_wr = 1'b1; reg_addr = ADDR_PEND; reg_wdata = 32'd1;
    @(negedge clk);
    base_stb = 1'b0; reg_wr = 1'b0;
    chk("R8 expiry beats clear", 32'(tick_irq), 32'd1);
    rd(ADDR_LIVE, v); chk("R5 reload to 3", v, 32'd3);
    wr(ADDR_PEND, 32'd1); chk("R8 later clear", 32'(tick_irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_start_zero;
    t_count_filter;
    t_basic;
    t_prescale;
    t_sel_gated;
    t_tick_stop;
    t_reenable;
    t_collision;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule